// File: doc/BRIEF.md
# Pulse-and-Verify EPROM Programming Sequencer

This block sits on the programmer side of a byte-wide UV-erasable or one-time-programmable memory and writes a contiguous range of bytes into it. After a start command it walks the range upward from a start address. At each location it first reads the present contents and asks a byte source for the intended value. A cell can only be moved from 1 to 0, so a byte that needs a 0 turned back into a 1 is refused before any pulse is given. Otherwise the block gives fixed-width program pulses, each followed by a read-back, until the byte matches or a pulse budget runs out.

During this phase the block requests the high programming supply and a raised core supply. Once the last location has been written, both requests drop. After a settling wait the whole range is read once more and compared with the source. Completion is reported on a done flag, together with an error flag, a two-bit error code and the address that failed. These stay valid until the next accepted start. The pulse width is given in microseconds and turned into a cycle count from the clock-frequency parameter.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset, rom_pgm_n and rom_oe_n are 1, and rom_dq_oe, vpp_req, vcc_hi_req, busy, done and err are all 0.
- R2: Every program pulse holds rom_pgm_n low for exactly PULSE_CYC = (CLK_HZ/1e6)*PULSE_US cycles. Throughout the pulse rom_oe_n is 1, rom_dq_oe is 1 with the target byte on rom_dq_out, and vpp_req and vcc_hi_req are both 1.
- R3: rom_oe_n is never 0 while rom_pgm_n is 0 or rom_dq_oe is 1. Every read during the programming phase happens with vpp_req at 1.
- R4: Each location is read once before any pulse and once after every pulse. Pulsing stops at the first matching read-back, and a location that already holds its target byte gets no pulse.
- R5: If the read-back still differs after MAX_PULSES pulses, the run ends with err=1, err_code=2 and err_addr equal to that location. No location after it is touched.
- R6: If the target byte has a 1 in a bit where the present contents hold 0, the run ends with err=1, err_code=1 and err_addr equal to that location. That location gets no pulse and no later location is touched.
- R7: Locations start_addr to start_addr+byte_count-1 are visited in ascending order, and no location outside that range is pulsed. After a clean run every location in the range holds its target byte.
- R8: After the last location, vpp_req and vcc_hi_req are both 0 and each location in the range is read exactly once more. The first mismatch ends the run with err=1, err_code=3 and err_addr equal to that location. vcc_hi_req is never 1 while vpp_req is 0.
- R9: busy is 1 from an accepted start until completion. On completion done is 1 and busy is 0, and done, err, err_code and err_addr then hold until the next start. A start while busy has no effect.
- R10: A start with byte_count = 0 completes with done=1 and err=0, with no read and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start command, accepted when not busy |
| start_addr | input | AW | First location of the range |
| byte_count | input | AW+1 | Number of locations to program |
| src_addr | output | AW | Location whose intended value is requested |
| src_data | input | DW | Intended value for src_addr |
| rom_addr | output | AW | Memory address bus |
| rom_dq_out | output | DW | Data driven toward the memory |
| rom_dq_oe | output | 1 | Drive enable for rom_dq_out |
| rom_dq_in | input | DW | Data read from the memory |
| rom_pgm_n | output | 1 | Chip-enable / program strobe, active low |
| rom_oe_n | output | 1 | Memory output enable, active low |
| vpp_req | output | 1 | Request for the high programming supply |
| vcc_hi_req | output | 1 | Request for the raised core supply |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (held) |
| err | output | 1 | Run finished with an error (held) |
| err_code | output | 2 | 1 bit conflict, 2 pulse limit, 3 final verify mismatch |
| err_addr | output | AW | Location where the error was found |

## Verification
The hardest outcome to reach from the ports is a final-verify mismatch. A byte that passed its per-pulse read-back reads back the same way again, so a correct run never fails at that stage. The bench's memory model therefore flips one bit of one chosen location, but only on reads taken while the programming supply request is low. This exposes the error in the nominal-supply pass alone. The pulse limit is reached in a similar way: the model gives each location its own count of pulses needed before its cells change, and one location is set to need more than the budget. Exactly the budget is also run, as the passing boundary.

// File: rtl/eprom_prog_pkg.sv
// Shared types for the EPROM programming sequencer.
// Assumes: consumers import the package; the encodings below are visible at the ports.
package eprom_prog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREAD,
        ST_PCHECK,
        ST_PULSE,
        ST_RECOVER,
        ST_VREAD,
        ST_VCHECK,
        ST_STEP,
        ST_SETTLE,
        ST_FREAD,
        ST_FCHECK,
        ST_END
    } seq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_CONFLICT = 2'd1,
        ERR_PULSES   = 2'd2,
        ERR_FINAL    = 2'd3
    } err_code_t;

endpackage

// File: rtl/eprom_cycle_timer.sv
// Down-counting interval timer.
// A load sets the count to N-1, and expired is high on the last cycle of an
// N-cycle interval. Assumes the owner loads on every state entry that needs timing.
module eprom_cycle_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    // Count down to zero and hold there until reloaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/eprom_addr_walker.sv
// Address stepper for one pass over the range.
// Loads a base and a span, advances by one per step, and flags the last location.
// Assumes: the owner never steps past the last location and never loads a span of 0.
module eprom_addr_walker #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [AW:0]   span,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [AW-1:0] addr_q;
    logic [AW:0]   left_q;

    // Hold the current location and the number of locations still to visit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
        end else if (load) begin
            addr_q <= base;
            left_q <= span;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
        end
    end

    assign addr = addr_q;
    assign last = (left_q == {{AW{1'b0}}, 1'b1});

    AST_WALK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (left_q > {{AW{1'b0}}, 1'b1})); // R7

endmodule

// File: rtl/eprom_byte_judge.sv
// Compares a byte read back from the memory with the wanted byte.
// conflict: some bit needs a 0 -> 1 change, which programming cannot make.
// match: the two bytes are equal. Purely combinational.
module eprom_byte_judge #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] want,
    output logic          conflict,
    output logic          match
);
    logic [DW-1:0] blocked;
    logic [DW-1:0] differs;

    for (genvar b = 0; b < DW; b++) begin : g_bit
        // Per-bit classification of the two bytes.
        assign blocked[b] = want[b] & ~cur[b];
        assign differs[b] = want[b] ^ cur[b];
    end

    assign conflict = |blocked;
    assign match    = ~|differs;

endmodule

// File: rtl/eprom_prog_seq.sv
// Pulse-and-verify EPROM programming sequencer (top).
// Walks a range upward. At each location it: reads the location, refuses an
// impossible 0->1 change, then alternates fixed program pulses with
// read-backs until the byte matches or the pulse budget is spent. The range is
// then re-read at nominal supplies.
// Assumes: src_data answers src_addr combinationally; rom_dq_in is valid
// READ_WAIT cycles after rom_oe_n falls; supplies settle within SETTLE_CYC.
module eprom_prog_seq
    import eprom_prog_pkg::*;
#(
    parameter int AW         = 19,
    parameter int DW         = 8,
    parameter int CLK_HZ     = 250_000_000,
    parameter int PULSE_US   = 100,
    parameter int MAX_PULSES = 25,
    parameter int READ_WAIT  = 4,
    parameter int SETTLE_CYC = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [AW:0]   byte_count,
    output logic [AW-1:0] src_addr,
    input  logic [DW-1:0] src_data,
    output logic [AW-1:0] rom_addr,
    output logic [DW-1:0] rom_dq_out,
    output logic          rom_dq_oe,
    input  logic [DW-1:0] rom_dq_in,
    output logic          rom_pgm_n,
    output logic          rom_oe_n,
    output logic          vpp_req,
    output logic          vcc_hi_req,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [1:0]    err_code,
    output logic [AW-1:0] err_addr
);
    localparam int PULSE_CYC = (CLK_HZ / 1_000_000) * PULSE_US;
    localparam int TW        = $clog2(PULSE_CYC + READ_WAIT + SETTLE_CYC + 1);
    localparam int PW        = $clog2(MAX_PULSES + 1);
    localparam logic [TW-1:0] T_PULSE  = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] T_READ   = TW'(READ_WAIT - 1);
    localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_CYC - 1);
    localparam logic [PW-1:0] P_LIMIT  = PW'(MAX_PULSES);

    seq_state_t    state_q, state_nxt;
    logic [AW-1:0] start_q;
    logic [AW:0]   count_q;
    logic [DW-1:0] rd_q, tgt_q;
    logic [PW-1:0] pulse_cnt_q;
    logic          done_q, err_q;
    err_code_t     code_q;
    logic [AW-1:0] eaddr_q;

    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          walk_load, walk_step, walk_last;
    logic [AW-1:0] walk_addr, walk_base;
    logic [AW:0]   walk_span;
    logic          conflict, match;
    logic          accept, in_read, fin_ok, fin_err;
    err_code_t     fin_code;

    assign accept  = start && (state_q == ST_IDLE || state_q == ST_END);
    assign in_read = (state_q == ST_PREAD) || (state_q == ST_VREAD) || (state_q == ST_FREAD);

    eprom_cycle_timer #(.TW(TW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    eprom_addr_walker #(.AW(AW)) i_walker (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (walk_load),
        .base  (walk_base),
        .span  (walk_span),
        .step  (walk_step),
        .addr  (walk_addr),
        .last  (walk_last)
    );

    eprom_byte_judge #(.DW(DW)) i_judge (
        .cur      (rd_q),
        .want     (tgt_q),
        .conflict (conflict),
        .match    (match)
    );

    // Next-state, walker control and completion decisions.
    always_comb begin
        state_nxt = state_q;
        walk_load = 1'b0;
        walk_step = 1'b0;
        fin_ok    = 1'b0;
        fin_err   = 1'b0;
        fin_code  = ERR_NONE;
        unique case (state_q)
            ST_IDLE, ST_END: begin
                if (accept) begin
                    if (byte_count == '0) begin
                        state_nxt = ST_END;
                        fin_ok    = 1'b1;
                    end else begin
                        state_nxt = ST_PREAD;
                        walk_load = 1'b1;
                    end
                end
            end
            ST_PREAD:   if (tmr_zero) state_nxt = ST_PCHECK;
            ST_PCHECK: begin
                if (conflict) begin
                    state_nxt = ST_END;
                    fin_err   = 1'b1;
                    fin_code  = ERR_CONFLICT;
                end else if (match) begin
                    state_nxt = ST_STEP;
                end else begin
                    state_nxt = ST_PULSE;
                end
            end
            ST_PULSE:   if (tmr_zero) state_nxt = ST_RECOVER;
            ST_RECOVER: state_nxt = ST_VREAD;
            ST_VREAD:   if (tmr_zero) state_nxt = ST_VCHECK;
            ST_VCHECK: begin
                if (match) begin
                    state_nxt = ST_STEP;
                end else if (pulse_cnt_q == P_LIMIT) begin
                    state_nxt = ST_END;
                    fin_err   = 1'b1;
                    fin_code  = ERR_PULSES;
                end else begin
                    state_nxt = ST_PULSE;
                end
            end
            ST_STEP: begin
                if (walk_last) begin
                    state_nxt = ST_SETTLE;
                    walk_load = 1'b1;
                end else begin
                    state_nxt = ST_PREAD;
                    walk_step = 1'b1;
                end
            end
            ST_SETTLE:  if (tmr_zero) state_nxt = ST_FREAD;
            ST_FREAD:   if (tmr_zero) state_nxt = ST_FCHECK;
            ST_FCHECK: begin
                if (!match) begin
                    state_nxt = ST_END;
                    fin_err   = 1'b1;
                    fin_code  = ERR_FINAL;
                end else if (walk_last) begin
                    state_nxt = ST_END;
                    fin_ok    = 1'b1;
                end else begin
                    state_nxt = ST_FREAD;
                    walk_step = 1'b1;
                end
            end
            default:    state_nxt = ST_IDLE;
        endcase
    end

    assign walk_base = accept ? start_addr : start_q;
    assign walk_span = accept ? byte_count : count_q;

    // Timer interval chosen by the state being entered.
    always_comb begin
        tmr_load = (state_nxt != state_q);
        unique case (state_nxt)
            ST_PULSE:                     tmr_val = T_PULSE;
            ST_PREAD, ST_VREAD, ST_FREAD: tmr_val = T_READ;
            ST_SETTLE:                    tmr_val = T_SETTLE;
            default:                      tmr_val = '0;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // Capture the run parameters when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            count_q <= '0;
        end else if (accept) begin
            start_q <= start_addr;
            count_q <= byte_count;
        end
    end

    // Latch read-back and wanted byte at the end of each read window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            tgt_q <= '0;
        end else if (in_read && tmr_zero) begin
            rd_q  <= rom_dq_in;
            tgt_q <= src_data;
        end
    end

    // Count the pulses given to the current location.
    always_ff @(posedge clk) begin
        if (!rst_n)                             pulse_cnt_q <= '0;
        else if (state_q == ST_PCHECK)          pulse_cnt_q <= '0;
        else if (state_q == ST_PULSE && tmr_zero) pulse_cnt_q <= pulse_cnt_q + 1'b1;
    end

    // Completion status, held until the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            code_q  <= ERR_NONE;
            eaddr_q <= '0;
        end else if (fin_ok || fin_err) begin
            done_q  <= 1'b1;
            err_q   <= fin_err;
            code_q  <= fin_code;
            eaddr_q <= fin_err ? walk_addr : '0;
        end else if (accept) begin
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            code_q  <= ERR_NONE;
            eaddr_q <= '0;
        end
    end

    assign src_addr   = walk_addr;
    assign rom_addr   = walk_addr;
    assign rom_dq_out = tgt_q;
    assign rom_dq_oe  = (state_q == ST_PULSE);
    assign rom_pgm_n  = (state_q != ST_PULSE);
    assign rom_oe_n   = !in_read;
    assign vpp_req    = (state_q == ST_PREAD)   || (state_q == ST_PCHECK) ||
                        (state_q == ST_PULSE)   || (state_q == ST_RECOVER) ||
                        (state_q == ST_VREAD)   || (state_q == ST_VCHECK) ||
                        (state_q == ST_STEP);
    assign vcc_hi_req = vpp_req;
    assign busy       = (state_q != ST_IDLE) && (state_q != ST_END);
    assign done       = done_q;
    assign err        = err_q;
    assign err_code   = code_q;
    assign err_addr   = eaddr_q;

    // Length of the current low run on the program strobe, for the width check.
    logic [31:0] low_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n || rom_pgm_n) low_run_q <= '0;
        else                     low_run_q <= low_run_q + 1'b1;
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_pgm_n) |-> (low_run_q == 32'(PULSE_CYC))); // R2
    AST_PULSE_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_pgm_n |-> (rom_oe_n && rom_dq_oe && vpp_req && vcc_hi_req)); // R2
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> (rom_pgm_n && !rom_dq_oe)); // R3
    AST_PULSE_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt_q <= P_LIMIT); // R5
    AST_CORE_WITH_VPP: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_hi_req |-> vpp_req); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && err_code != 2'd0)); // R5
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(err) && $stable(err_code) && $stable(err_addr))); // R9

endmodule

// File: tb/test_eprom_prog_seq.sv
// Bench: behavioural memory model with per-location pulse needs,
// random ranges plus directed corner cases, expected results from a bench function.
module test_eprom_prog_seq;
    localparam int AW = 6, DW = 8, NLOC = 64;
    localparam int CLK_HZ = 1_000_000, PULSE_US = 100, MAXP = 6;
    localparam int PCYC = (CLK_HZ / 1_000_000) * PULSE_US;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, start;
    logic [AW-1:0] start_addr, src_addr, rom_addr, err_addr;
    logic [AW:0]   byte_count;
    logic [DW-1:0] src_data, rom_dq_out, rom_dq_in;
    logic          rom_dq_oe, rom_pgm_n, rom_oe_n, vpp_req, vcc_hi_req;
    logic          busy, done, err;
    logic [1:0]    err_code;

    eprom_prog_seq #(.AW(AW), .DW(DW), .CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US),
                     .MAX_PULSES(MAXP), .READ_WAIT(3), .SETTLE_CYC(4)) i_eprom_prog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .src_addr(src_addr), .src_data(src_data),
        .rom_addr(rom_addr), .rom_dq_out(rom_dq_out), .rom_dq_oe(rom_dq_oe),
        .rom_dq_in(rom_dq_in), .rom_pgm_n(rom_pgm_n), .rom_oe_n(rom_oe_n),
        .vpp_req(vpp_req), .vcc_hi_req(vcc_hi_req), .busy(busy), .done(done),
        .err(err), .err_code(err_code), .err_addr(err_addr));

    int checks = 0, errors = 0, cyc = 0;
    logic [7:0] mem [NLOC];
    logic [7:0] init_m [NLOC];
    logic [7:0] tgt [NLOC];
    logic [7:0] exp_mem [NLOC];
    int need [NLOC], seen_p [NLOC], seen_pr [NLOC], seen_fr [NLOC];
    int exp_p [NLOC], exp_pr [NLOC], exp_fr [NLOC];
    int exp_code, exp_ea, low_w, last_a;
    bit leak_on, bad_cond, order_bad, prev_oe;
    int leak_a;
    logic [7:0] cap_d;
    int cap_a;

    assign src_data  = tgt[src_addr];
    assign rom_dq_in = (!rom_oe_n && rom_pgm_n) ?
        (mem[rom_addr] ^ ((leak_on && !vpp_req && int'(rom_addr) == leak_a) ? 8'h01 : 8'h00)) : 8'hFF;

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    always @(posedge clk) cyc++;

    // Watchdog: a hung run counts as a failed check.
    initial begin
        wait (cyc > 150000);
        check(1'b0, "R9", "watchdog expired", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Memory model, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!rom_pgm_n) begin
                low_w++;
                cap_a = int'(rom_addr);
                cap_d = rom_dq_out;
                if (!(rom_oe_n && rom_dq_oe && vpp_req && vcc_hi_req)) bad_cond = 1'b1;
            end else if (low_w != 0) begin
                check(low_w == PCYC, "R2", "pulse width", low_w, PCYC);
                check(!bad_cond, "R2", "pulse control lines", bad_cond, 0);
                seen_p[cap_a]++;
                if (seen_p[cap_a] >= need[cap_a]) mem[cap_a] = mem[cap_a] & cap_d;
                low_w = 0;
                bad_cond = 1'b0;
            end
            if (prev_oe && !rom_oe_n) begin
                if (vpp_req) begin
                    seen_pr[rom_addr]++;
                    if (int'(rom_addr) < last_a) order_bad = 1'b1;
                    last_a = int'(rom_addr);
                end else begin
                    seen_fr[rom_addr]++;
                end
            end
        end
        prev_oe = rom_oe_n;
    end

    function automatic void compute_expect(int sa, int cnt);
        bit stop = 1'b0;
        for (int a = 0; a < NLOC; a++) begin
            exp_p[a] = 0; exp_pr[a] = 0; exp_fr[a] = 0; exp_mem[a] = init_m[a];
        end
        exp_code = 0; exp_ea = 0;
        for (int i = 0; i < cnt && !stop; i++) begin
            int a = sa + i;
            exp_pr[a] = 1;
            if ((tgt[a] & ~init_m[a]) != 8'h00) begin
                exp_code = 1; exp_ea = a; stop = 1'b1;
            end else if (tgt[a] != init_m[a]) begin
                if (need[a] > MAXP) begin
                    exp_p[a] = MAXP; exp_pr[a] = MAXP + 1;
                    exp_code = 2; exp_ea = a; stop = 1'b1;
                end else begin
                    exp_p[a] = need[a]; exp_pr[a] = need[a] + 1; exp_mem[a] = tgt[a];
                end
            end
        end
        if (!stop) begin
            for (int i = 0; i < cnt; i++) begin
                int a = sa + i;
                exp_fr[a] = 1;
                if (leak_on && a == leak_a) begin
                    exp_code = 3; exp_ea = a; break;
                end
            end
        end
    endfunction

    task automatic rand_fill();
        for (int a = 0; a < NLOC; a++) begin
            init_m[a] = 8'($urandom) | 8'($urandom);
            tgt[a]    = (($urandom % 4) == 0) ? init_m[a] : (init_m[a] & 8'($urandom));
            need[a]   = 1 + int'($urandom % 4);
        end
    endtask

    task automatic run(string tag, int sa, int cnt, bit poke);
        int bad_a;
        for (int a = 0; a < NLOC; a++) begin
            mem[a] = init_m[a]; seen_p[a] = 0; seen_pr[a] = 0; seen_fr[a] = 0;
        end
        last_a = 0; order_bad = 1'b0;
        compute_expect(sa, cnt);
        @(negedge clk);
        start_addr = AW'(sa); byte_count = (AW+1)'(cnt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (300) @(negedge clk);
            check(busy == 1'b1, "R9", {tag, " busy during run"}, busy, 1);
            start_addr = '0; byte_count = 1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        check(busy == 1'b0, "R9", {tag, " busy at end"}, busy, 0);
        check(int'(err_code) == exp_code, exp_code == 1 ? "R6" : exp_code == 2 ? "R5" :
              exp_code == 3 ? "R8" : "R7", {tag, " err_code"}, err_code, exp_code);
        check(err == (exp_code != 0), "R9", {tag, " err flag"}, err, exp_code != 0);
        if (exp_code != 0)
            check(int'(err_addr) == exp_ea, "R5", {tag, " err_addr"}, err_addr, exp_ea);
        bad_a = -1;
        for (int a = 0; a < NLOC; a++) if (seen_p[a] != exp_p[a] && bad_a < 0) bad_a = a;
        check(bad_a < 0, "R4", {tag, " pulses per location"}, bad_a < 0 ? 0 : seen_p[bad_a],
              bad_a < 0 ? 0 : exp_p[bad_a]);
        bad_a = -1;
        for (int a = 0; a < NLOC; a++) if (seen_pr[a] != exp_pr[a] && bad_a < 0) bad_a = a;
        check(bad_a < 0, "R4", {tag, " program-phase reads"}, bad_a < 0 ? 0 : seen_pr[bad_a],
              bad_a < 0 ? 0 : exp_pr[bad_a]);
        bad_a = -1;
        for (int a = 0; a < NLOC; a++) if (seen_fr[a] != exp_fr[a] && bad_a < 0) bad_a = a;
        check(bad_a < 0, "R8", {tag, " final reads at nominal supply"}, bad_a < 0 ? 0 : seen_fr[bad_a],
              bad_a < 0 ? 0 : exp_fr[bad_a]);
        bad_a = -1;
        for (int a = 0; a < NLOC; a++) if (mem[a] != exp_mem[a] && bad_a < 0) bad_a = a;
        check(bad_a < 0, "R7", {tag, " memory contents"}, bad_a < 0 ? 0 : int'(mem[bad_a]),
              bad_a < 0 ? 0 : int'(exp_mem[bad_a]));
        check(!order_bad, "R7", {tag, " ascending order"}, order_bad, 0);
        repeat (3) @(negedge clk);
        check(done && int'(err_code) == exp_code, "R9", {tag, " status held"}, done, 1);
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd2718);
        rst_n = 1'b0; start = 1'b0; start_addr = '0; byte_count = '0;
        leak_on = 1'b0; leak_a = 0; low_w = 0; bad_cond = 1'b0; prev_oe = 1'b1;
        rand_fill();
        for (int a = 0; a < NLOC; a++) mem[a] = init_m[a];
        repeat (4) @(negedge clk);
        check(rom_pgm_n && rom_oe_n && !rom_dq_oe && !vpp_req && !vcc_hi_req &&
              !busy && !done && !err, "R1", "reset state", 0, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // Random range, plus a start while busy that must be ignored (R9).
        rand_fill();
        init_m[5] = 8'hFF; tgt[5] = 8'h33; need[5] = 4;
        run("random-a", 5, 10, 1'b1);
        // Range ending at the top location (R7).
        rand_fill();
        run("top-edge", 58, 6, 1'b0);
        // Zero-length range (R10).
        run("empty", 10, 0, 1'b0);
        // Impossible 0->1 change in the third location (R6).
        rand_fill();
        init_m[22] = 8'h7F; tgt[22] = 8'hC0;
        run("conflict", 20, 5, 1'b0);
        // Location needing more pulses than the budget (R5).
        rand_fill();
        init_m[31] = 8'hFF; tgt[31] = 8'h0F; need[31] = MAXP + 1;
        run("limit", 30, 4, 1'b0);
        // Every location needing exactly the budget (R4 boundary).
        rand_fill();
        for (int a = 40; a < 43; a++) begin init_m[a] = 8'hFF; tgt[a] = 8'hA5; need[a] = MAXP; end
        run("at-budget", 40, 3, 1'b0);
        // Bit that drops out once the programming supply is released (R8).
        rand_fill();
        init_m[47] = 8'hFF; tgt[47] = 8'h3C;
        leak_on = 1'b1; leak_a = 47;
        run("final-miss", 45, 5, 1'b0);
        leak_on = 1'b0;
        // Single location already holding its byte (R4: no pulse).
        rand_fill();
        tgt[0] = init_m[0];
        run("already-set", 0, 1, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule